// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block receives configuration words for a two-channel (IF and RF) frequency synthesizer over a three-wire link: a serial clock, a serial data line and a load strobe. A fast system clock oversamples all three lines. A 22-bit frame is shifted in, most significant bit first. It holds a 20-bit data word followed by a 2-bit address. When the strobe rises, the data word is copied into the one latch that the address selects.

There are four latches: a reference word and a divider word for each channel. The same data-word bit positions carry different fields depending on which latch holds them. The block decodes every latch into named outputs. A reference word gives the reference division ratio and five mode flags. A divider word gives the swallow count, the main count, the prescaler modulus select and power-down. Output index 0 is the IF channel and index 1 is the RF channel.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset every latch holds zero, so every decoded output is zero.
- R2: A bit is taken from ser_dat_i on each rising edge of ser_clk_i and enters the shift register at the least significant end. Only the last 22 bits shifted before the strobe are used; any earlier bits fall out of the register.
- R3: The last two bits shifted form the address, with the first of them as the address MSB. Address 00 selects the IF reference latch, 01 the RF reference latch, 10 the IF divider latch and 11 the RF divider latch. A strobe writes only the addressed latch, and the other three keep their contents.
- R4: In a reference word, data bits 14:0 are the reference division ratio (3 to 32767). The mode bits are: bit 15 phase-detector polarity, bit 16 charge-pump tri-state, bit 17 charge-pump high current, bit 18 lock-detect enable, and bit 19 divider-output select.
- R5: In a divider word, data bits 6:0 are the swallow count, bits 17:7 are the main count, bit 18 is prescaler select and bit 19 is power-down.
- R6: Latched values change only on a rising edge of ser_le_i. Shifting with the strobe low, holding the strobe high, or dropping the strobe leaves every output unchanged.
- R7: Once a rising edge of ser_le_i has been set up before a system clock edge, the new latch value appears after the third rising clk edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than ser_clk_i |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_le_i | input | 1 | Load strobe; its rising edge commits the frame |
| ref_div_o | output | 2x15 | Reference division ratio per channel |
| pd_pol_o | output | 2 | Phase-detector polarity per channel |
| cp_tri_o | output | 2 | Charge-pump tri-state per channel |
| cp_hi_o | output | 2 | Charge-pump high-current level per channel |
| lock_en_o | output | 2 | Lock-detect enable per channel |
| div_out_sel_o | output | 2 | Divider-output select per channel |
| swal_o | output | 2x7 | Swallow count per channel |
| main_o | output | 2x11 | Main count per channel |
| psel_o | output | 2 | Prescaler modulus select per channel |
| pdn_o | output | 2 | Power-down per channel |

## Verification
A serial edge takes two synchronizer stages plus one edge-detect register before it acts, so a shift or a latch write lands on the third system clock edge after the line changes. The bench changes every serial line on a falling system edge and keeps each serial level for three system cycles. This way each bit is shifted well before the data line moves again. For every strobe, the bench reads the addressed field set after the second system edge, where it must still be old, and again after the third, where it must be new. All full-word comparisons are made only once the strobe has settled, so the stage count alone decides when each result is due.

// File: rtl/serial_cfg_pkg.sv
`timescale 1ns/1ps
package serial_cfg_pkg;
   // latch selector carried in the trailing frame bits
   typedef enum logic [1:0] {
      SEL_IF_REF = 2'b00,
      SEL_RF_REF = 2'b01,
      SEL_IF_DIV = 2'b10,
      SEL_RF_DIV = 2'b11
   } latch_sel_e;

   localparam int REF_MODE_BITS = 5;
   localparam int DIV_MODE_BITS = 2;
   localparam int NUM_CHAN      = 2;
   localparam int SERIAL_LINES  = 3;   // clock, data, strobe
endpackage

// File: rtl/scl_sync_edge.sv
`timescale 1ns/1ps
module scl_sync_edge #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] level_o,
   output logic [WIDTH-1:0] rise_o
);
   logic [WIDTH-1:0] last_q;

   for (genvar b = 0; b < WIDTH; b++) begin : g_line
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
      end
      assign level_o[b] = chain_q[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= '0;
      else        last_q <= level_o;
   end

   assign rise_o = level_o & ~last_q;
endmodule

// File: rtl/scl_shifter.sv
`timescale 1ns/1ps
module scl_shifter #(
   parameter int FRAME_W = 22
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en,
   input  logic               bit_i,
   output logic [FRAME_W-1:0] frame_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        frame_o <= '0;
      else if (shift_en) frame_o <= {frame_o[FRAME_W-2:0], bit_i};
   end
endmodule

// File: rtl/scl_latch_bank.sv
`timescale 1ns/1ps
module scl_latch_bank #(
   parameter int DATA_W = 20,
   parameter int ADDR_W = 2,
   localparam int NWORD = 1 << ADDR_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         commit_i,
   input  logic [ADDR_W-1:0]            addr_i,
   input  logic [DATA_W-1:0]            data_i,
   output logic [NWORD-1:0][DATA_W-1:0] word_o
);
   for (genvar i = 0; i < NWORD; i++) begin : g_word
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            word_q <= '0;
         else if (commit_i && addr_i == MY_ADDR) word_q <= data_i;
      end
      assign word_o[i] = word_q;
   end
endmodule

// File: rtl/serial_cfg_loader.sv
`timescale 1ns/1ps
module serial_cfg_loader
   import serial_cfg_pkg::*;
#(
   parameter int REF_W       = 15,
   parameter int SWAL_W      = 7,
   parameter int MAIN_W      = 11,
   parameter int DATA_W      = 20,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             ser_clk_i,
   input  logic                             ser_dat_i,
   input  logic                             ser_le_i,
   output logic [NUM_CHAN-1:0][REF_W-1:0]   ref_div_o,
   output logic [NUM_CHAN-1:0]              pd_pol_o,
   output logic [NUM_CHAN-1:0]              cp_tri_o,
   output logic [NUM_CHAN-1:0]              cp_hi_o,
   output logic [NUM_CHAN-1:0]              lock_en_o,
   output logic [NUM_CHAN-1:0]              div_out_sel_o,
   output logic [NUM_CHAN-1:0][SWAL_W-1:0]  swal_o,
   output logic [NUM_CHAN-1:0][MAIN_W-1:0]  main_o,
   output logic [NUM_CHAN-1:0]              psel_o,
   output logic [NUM_CHAN-1:0]              pdn_o
);
   localparam int FRAME_W  = DATA_W + ADDR_W;
   localparam int NWORD    = 1 << ADDR_W;
   localparam int POS_POL  = REF_W;
   localparam int POS_TRI  = REF_W + 1;
   localparam int POS_CUR  = REF_W + 2;
   localparam int POS_LD   = REF_W + 3;
   localparam int POS_FO   = REF_W + 4;
   localparam int POS_MAIN = SWAL_W;
   localparam int POS_PSEL = SWAL_W + MAIN_W;
   localparam int POS_PDN  = SWAL_W + MAIN_W + 1;

   initial begin
      if (REF_W + REF_MODE_BITS != DATA_W)
         $fatal(1, "reference layout does not fill the data word");
      if (SWAL_W + MAIN_W + DIV_MODE_BITS != DATA_W)
         $fatal(1, "divider layout does not fill the data word");
      if (ADDR_W != 2)
         $fatal(1, "address must select exactly four latches");
      if (SYNC_STAGES < 2)
         $fatal(1, "synchronizer needs at least two stages");
   end

   logic [SERIAL_LINES-1:0] line_lvl, line_rise;
   logic                    sh_rise, le_rise, dat_s;
   logic [FRAME_W-1:0]      frame_q;
   logic [NWORD-1:0][DATA_W-1:0] latch_words;

   scl_sync_edge #(.WIDTH(SERIAL_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({ser_le_i, ser_dat_i, ser_clk_i}),
      .level_o (line_lvl),
      .rise_o  (line_rise)
   );

   assign sh_rise = line_rise[0];
   assign dat_s   = line_lvl[1];
   assign le_rise = line_rise[2];

   scl_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (sh_rise),
      .bit_i    (dat_s),
      .frame_o  (frame_q)
   );

   scl_latch_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit_i (le_rise),
      .addr_i   (frame_q[ADDR_W-1:0]),
      .data_i   (frame_q[FRAME_W-1:ADDR_W]),
      .word_o   (latch_words)
   );

   // channel c: reference word at address c, divider word at address 2+c
   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      logic [DATA_W-1:0] ref_w, div_w;
      assign ref_w = latch_words[c];
      assign div_w = latch_words[NUM_CHAN + c];

      assign ref_div_o[c]     = ref_w[REF_W-1:0];
      assign pd_pol_o[c]      = ref_w[POS_POL];
      assign cp_tri_o[c]      = ref_w[POS_TRI];
      assign cp_hi_o[c]       = ref_w[POS_CUR];
      assign lock_en_o[c]     = ref_w[POS_LD];
      assign div_out_sel_o[c] = ref_w[POS_FO];

      assign swal_o[c] = div_w[SWAL_W-1:0];
      assign main_o[c] = div_w[POS_MAIN +: MAIN_W];
      assign psel_o[c] = div_w[POS_PSEL];
      assign pdn_o[c]  = div_w[POS_PDN];
   end
endmodule

// File: rtl/serial_cfg_loader_chk.sv
`timescale 1ns/1ps
module serial_cfg_loader_chk #(
   parameter int REF_W  = 15,
   parameter int SWAL_W = 7,
   parameter int MAIN_W = 11,
   parameter int DATA_W = 20,
   parameter int ADDR_W = 2,
   localparam int FRAME_W = DATA_W + ADDR_W,
   localparam int NWORD   = 1 << ADDR_W
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         sh_rise,
   input logic                         le_rise,
   input logic                         dat_s,
   input logic [FRAME_W-1:0]           frame_q,
   input logic [NWORD-1:0][DATA_W-1:0] latch_words,
   input logic [1:0][REF_W-1:0]        ref_div_o,
   input logic [1:0]                   pd_pol_o,
   input logic [1:0][SWAL_W-1:0]       swal_o,
   input logic [1:0][MAIN_W-1:0]       main_o,
   input logic [1:0]                   pdn_o
);
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] data;
   assign addr = frame_q[ADDR_W-1:0];
   assign data = frame_q[FRAME_W-1:ADDR_W];

   // R2
   shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sh_rise |=> frame_q == $past({frame_q[FRAME_W-2:0], dat_s}));

   // R2
   shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_rise |=> $stable(frame_q));

   // R6
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !le_rise |=> $stable(latch_words));

   for (genvar i = 0; i < NWORD; i++) begin : g_w
      localparam logic [ADDR_W-1:0] A = ADDR_W'(i);
      // R3
      addr_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (le_rise && addr != A) |=> $stable(latch_words[i]));
      // R3
      addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (le_rise && addr == A) |=> latch_words[i] == $past(data));
   end

   for (genvar c = 0; c < 2; c++) begin : g_c
      localparam logic [ADDR_W-1:0] AR = ADDR_W'(c);
      localparam logic [ADDR_W-1:0] AD = ADDR_W'(2 + c);
      // R4
      ref_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (le_rise && addr == AR) |=>
            (ref_div_o[c] == $past(data[REF_W-1:0])) &&
            (pd_pol_o[c] == $past(data[REF_W])));
      // R5
      div_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (le_rise && addr == AD) |=>
            (swal_o[c] == $past(data[SWAL_W-1:0])) &&
            (main_o[c] == $past(data[SWAL_W +: MAIN_W])) &&
            (pdn_o[c] == $past(data[DATA_W-1])));
   end
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(
   .REF_W(REF_W), .SWAL_W(SWAL_W), .MAIN_W(MAIN_W),
   .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sh_rise     (sh_rise),
   .le_rise     (le_rise),
   .dat_s       (dat_s),
   .frame_q     (frame_q),
   .latch_words (latch_words),
   .ref_div_o   (ref_div_o),
   .pd_pol_o    (pd_pol_o),
   .swal_o      (swal_o),
   .main_o      (main_o),
   .pdn_o       (pdn_o)
);

// File: tb/sim_serial_cfg_loader.sv
`timescale 1ns/1ps
module sim_serial_cfg_loader;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
   logic [1:0][14:0] ref_div;
   logic [1:0]       pd_pol, cp_tri, cp_hi, lock_en, div_sel, psel, pdn;
   logic [1:0][6:0]  swal;
   logic [1:0][10:0] mainc;

   int n_chk = 0;
   int n_fail = 0;
   logic [19:0] exp_w [4];

   always #2.5 clk = ~clk;

   serial_cfg_loader u0 (
      .clk(clk), .rst_n(rst_n),
      .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_le_i(ser_le),
      .ref_div_o(ref_div), .pd_pol_o(pd_pol), .cp_tri_o(cp_tri),
      .cp_hi_o(cp_hi), .lock_en_o(lock_en), .div_out_sel_o(div_sel),
      .swal_o(swal), .main_o(mainc), .psel_o(psel), .pdn_o(pdn)
   );

   // rebuild a data word from the ports using the R4/R5 layouts
   function automatic logic [19:0] observed(int i);
      if (i < 2) return {div_sel[i], lock_en[i], cp_hi[i], cp_tri[i], pd_pol[i], ref_div[i]};
      else       return {pdn[i-2], psel[i-2], mainc[i-2], swal[i-2]};
   endfunction

   task automatic chk(string tag, logic [19:0] act, logic [19:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      for (int i = 0; i < 4; i++)
         chk($sformatf("%s/%s word%0d", tag, (i < 2) ? "R4" : "R5", i), observed(i), exp_w[i]);
   endtask

   task automatic wait_neg(int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic send_bit(logic b);
      ser_dat = b; ser_clk = 1'b0; wait_neg(3);
      ser_clk = 1'b1;              wait_neg(3);
      ser_clk = 1'b0;
   endtask

   task automatic send_frame(logic [1:0] a, logic [19:0] d);
      logic [21:0] f;
      f = {d, a};
      for (int k = 21; k >= 0; k--) send_bit(f[k]);
      wait_neg(3);
   endtask

   // strobe with R7 latency checks, then full R3 check
   task automatic strobe(logic [1:0] a, logic [19:0] d);
      ser_le = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk($sformatf("R7 early word%0d", a), observed(a), exp_w[a]);
      @(posedge clk); @(negedge clk);
      exp_w[a] = d;
      chk($sformatf("R7 due word%0d", a), observed(a), exp_w[a]);
      wait_neg(3);
      ser_le = 1'b0;
      wait_neg(4);
      check_all("R3");
   endtask

   function automatic logic [19:0] pattern(int p);
      case (p)
         0: return 20'h00003;
         1: return 20'h07FFF;
         2: return 20'hFFFFF;
         3: return 20'hAAAAA;
         4: return 20'h55555;
         5: return (20'd3 << 7) | 20'd127;
         6: return 20'd2047 << 7;
         default: return 20'h80000 | 20'h40000 | 20'h08000;
      endcase
   endfunction

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) exp_w[i] = '0;
      wait_neg(4);
      check_all("R1");
      rst_n = 1'b1;
      wait_neg(4);
      check_all("R1");

      // sweep: every address under every pattern, plus the walking mode bits
      for (int p = 0; p < 8; p++) begin
         for (int a = 0; a < 4; a++) begin
            logic [19:0] d;
            d = pattern(p) ^ (20'(a) << (4 * a));
            send_frame(2'(a), d);
            check_all("R6 shift-only");
            strobe(2'(a), d);
         end
      end
      for (int b = 15; b < 20; b++) begin
         send_frame(2'b01, 20'(1) << b);
         strobe(2'b01, 20'(1) << b);
      end

      // R2: leading junk bits must fall out of the register
      for (int k = 0; k < 9; k++) send_bit(1'b1);
      send_frame(2'b10, 20'h01234);
      strobe(2'b10, 20'h01234);

      // R6: strobe held high while a new frame shifts, then dropped
      send_frame(2'b11, 20'h3C3C3);
      ser_le = 1'b1; wait_neg(6);
      exp_w[3] = 20'h3C3C3;
      check_all("R6 first-commit");
      send_frame(2'b11, 20'h0F0F0);
      check_all("R6 le-held");
      ser_le = 1'b0; wait_neg(6);
      check_all("R6 le-fall");
      strobe(2'b11, 20'h0F0F0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule